// File: doc/BRIEF.md
# Fetch-Block Branch Target Buffer

This block predicts where instruction fetch goes next. Fetch proceeds in aligned 16-byte blocks, one block per cycle. Each cycle the fetch unit presents a block address, and the buffer searches one set of a set-associative table for branches recorded inside that block. A block may hold several recorded branches, so more than one way can hit at once. Only branches at or after the byte where fetch enters the block can still be taken. Among those, the one with the lowest byte offset wins, and its stored target becomes the predicted next fetch address. When no branch qualifies, the prediction is the next sequential block.

A decode-stage corrector keeps the table accurate. It writes an entry when decode finds a branch the buffer missed or a wrong target. It drops an entry when a non-branch was predicted as a branch. It can also flush the whole table. The set is chosen by address bits [9:4] and the tag by bits [19:10]. With the default parameters the table has 64 sets of 4 ways. Direction prediction, return stacks and indirect targets are not part of this block.

Top module: `fblk_btb`

## Requirements
- R1: After reset every entry is invalid and `rs_valid` is 0, so every lookup misses until something is written.
- R2: A lookup selects the set with address bits [9:4]. It hits a way only if that way's stored tag equals address bits [19:10].
- R3: A hit qualifies only if its stored byte offset is greater than or equal to the entry offset, which is lookup address bits [3:0].
- R4: When several qualifying ways hit, the result reports the one with the smallest byte offset.
- R5: With no qualifying hit, `rs_hit` and `rs_cond` are 0. `rs_next` is the lookup address with bits [3:0] cleared, plus 16, wrapping at 32 bits.
- R6: On a qualifying hit, `rs_hit` is 1. `rs_next` is the stored target, `rs_off` is the stored offset and `rs_cond` is the stored conditional flag.
- R7: The result of a lookup appears on the outputs exactly one clock after `lk_valid` is sampled high, with `rs_valid` high. `rs_valid` is 0 in a cycle after `lk_valid` was low.
- R8: A write command (`cr_cmd` = 1) whose address matches a valid entry in tag and offset (bits [19:10] and [3:0]) rewrites that entry's target and flag in place. It does not use another way.
- R9: A write that matches no entry goes into the lowest-numbered invalid way of the set. If the set is full, it replaces the way named by that set's round-robin pointer, which starts at way 0 and advances by one on each such replacement.
- R10: A drop command (`cr_cmd` = 2) invalidates the entry whose tag and offset match `cr_addr`.
- R11: `cr_flush` invalidates every entry in one cycle. It overrides any write or drop in the same cycle.
- R12: A lookup in the same cycle as a corrector change to the same set sees the contents from before that change. Later lookups see the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Fetch address; bits [3:0] give the entry byte |
| rs_valid | output | 1 | Registered result is valid |
| rs_hit | output | 1 | A qualifying branch was found |
| rs_off | output | 4 | Byte offset of the chosen branch |
| rs_next | output | 32 | Predicted next fetch address |
| rs_cond | output | 1 | Chosen branch is conditional |
| cr_cmd | input | 2 | Corrector command: 0 none, 1 write, 2 drop |
| cr_addr | input | 32 | Address of the branch being written or dropped |
| cr_target | input | 32 | Target to record on a write |
| cr_cond | input | 1 | Conditional flag to record on a write |
| cr_flush | input | 1 | Invalidate the whole table |

## Verification
Directed sequences build one set up branch by branch. Lookups then enter that block at offsets below, between and above the recorded branches. This separates a correct earliest-offset pick from one that takes the first way, the last way or ignores the entry offset. Filling the set past its way count, rewriting an existing branch and dropping one show whether replacement follows free-way-first and then round-robin order, and whether in-place updates avoid using another way. Lookups with a foreign tag in the same set, a wrapping sequential address, and a write in the same cycle as a lookup cover tag compare, wrap-around and old-contents reads. A long fixed-seed random run then mixes writes, drops, rare flushes and lookups over a few sets and tags, checked against a bench model of the table.

// File: rtl/btb_pkg.sv
package btb_pkg;
   typedef enum logic [1:0] {
      BTB_NOP   = 2'd0,
      BTB_WRITE = 2'd1,
      BTB_DROP  = 2'd2
   } btb_cmd_e;
endpackage

// File: rtl/btb_pick.sv
module btb_pick #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 10,
   parameter int OFF_W = 4,
   parameter int TGT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WAYS-1:0]  way_vld,
   input  logic [TAG_W-1:0] way_tag  [WAYS],
   input  logic [OFF_W-1:0] way_off  [WAYS],
   input  logic [TGT_W-1:0] way_tgt  [WAYS],
   input  logic [WAYS-1:0]  way_cond,
   input  logic [TAG_W-1:0] look_tag,
   input  logic [OFF_W-1:0] look_off,
   output logic             any_hit,
   output logic [OFF_W-1:0] hit_off,
   output logic [TGT_W-1:0] hit_tgt,
   output logic             hit_cond,
   output logic [WAYS-1:0]  hit_sel
);
   logic [WAYS-1:0] qual;

   for (genvar w = 0; w < WAYS; w++) begin : g_qual
      assign qual[w] = way_vld[w] && (way_tag[w] == look_tag) && (way_off[w] >= look_off);
   end

   always_comb begin
      any_hit  = 1'b0;
      hit_off  = '0;
      hit_tgt  = '0;
      hit_cond = 1'b0;
      hit_sel  = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (qual[w] && (!any_hit || way_off[w] < hit_off)) begin
            any_hit  = 1'b1;
            hit_off  = way_off[w];
            hit_tgt  = way_tgt[w];
            hit_cond = way_cond[w];
            hit_sel  = '0;
            hit_sel[w] = 1'b1;
         end
      end
   end

   AST_PICK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_sel) && (any_hit == (qual != '0))); // R4
endmodule

// File: rtl/btb_store.sv
module btb_store
   import btb_pkg::*;
#(
   parameter int SET_W = 6,
   parameter int WAYS  = 4,
   parameter int TAG_W = 10,
   parameter int OFF_W = 4,
   parameter int TGT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set,
   output logic [WAYS-1:0]  rd_vld,
   output logic [TAG_W-1:0] rd_tag  [WAYS],
   output logic [OFF_W-1:0] rd_off  [WAYS],
   output logic [TGT_W-1:0] rd_tgt  [WAYS],
   output logic [WAYS-1:0]  rd_cond,
   input  btb_cmd_e         wr_cmd,
   input  logic [SET_W-1:0] wr_set,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [OFF_W-1:0] wr_off,
   input  logic [TGT_W-1:0] wr_tgt,
   input  logic             wr_cond,
   input  logic             flush
);
   localparam int SETS  = 1 << SET_W;
   localparam int WAY_W = $clog2(WAYS);

   logic [SETS-1:0][WAYS-1:0] vld_q;
   logic [TAG_W-1:0] tag_q  [SETS][WAYS];
   logic [OFF_W-1:0] off_q  [SETS][WAYS];
   logic [TGT_W-1:0] tgt_q  [SETS][WAYS];
   logic             cond_q [SETS][WAYS];
   logic [WAY_W-1:0] rr_q   [SETS];

   for (genvar w = 0; w < WAYS; w++) begin : g_read
      assign rd_vld[w]  = vld_q[rd_set][w];
      assign rd_tag[w]  = tag_q[rd_set][w];
      assign rd_off[w]  = off_q[rd_set][w];
      assign rd_tgt[w]  = tgt_q[rd_set][w];
      assign rd_cond[w] = cond_q[rd_set][w];
   end

   logic [WAYS-1:0]  w_match;
   logic [WAY_W-1:0] vic;
   logic             use_rr;
   logic             do_write;
   logic             do_drop;

   for (genvar w = 0; w < WAYS; w++) begin : g_match
      assign w_match[w] = vld_q[wr_set][w] && (tag_q[wr_set][w] == wr_tag)
                          && (off_q[wr_set][w] == wr_off);
   end

   assign do_write = (wr_cmd == BTB_WRITE) && !flush;
   assign do_drop  = (wr_cmd == BTB_DROP) && !flush;

   always_comb begin
      logic found;
      found  = 1'b0;
      vic    = rr_q[wr_set];
      use_rr = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (!found && w_match[w]) begin
            found = 1'b1;
            vic   = WAY_W'(w);
         end
      end
      for (int w = 0; w < WAYS; w++) begin
         if (!found && !vld_q[wr_set][w]) begin
            found = 1'b1;
            vic   = WAY_W'(w);
         end
      end
      if (!found) use_rr = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
      end else if (flush) begin
         vld_q <= '0;
      end else if (do_write) begin
         vld_q[wr_set][vic] <= 1'b1;
         if (use_rr) rr_q[wr_set] <= rr_q[wr_set] + 1'b1;
      end else if (do_drop) begin
         vld_q[wr_set] <= vld_q[wr_set] & ~w_match;
      end
   end

   always_ff @(posedge clk) begin
      if (do_write) begin
         tag_q[wr_set][vic]  <= wr_tag;
         off_q[wr_set][vic]  <= wr_off;
         tgt_q[wr_set][vic]  <= wr_tgt;
         cond_q[wr_set][vic] <= wr_cond;
      end
   end

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_q == '0)); // R11
   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      do_write |=> vld_q[$past(wr_set)][$past(vic)]); // R9
   AST_MATCH_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(w_match)); // R8
endmodule

// File: rtl/fblk_btb.sv
module fblk_btb
   import btb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 4,
   parameter int SET_W  = 6,
   parameter int TAG_W  = 10,
   parameter int WAYS   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              rs_valid,
   output logic              rs_hit,
   output logic [OFF_W-1:0]  rs_off,
   output logic [ADDR_W-1:0] rs_next,
   output logic              rs_cond,
   input  logic [1:0]        cr_cmd,
   input  logic [ADDR_W-1:0] cr_addr,
   input  logic [ADDR_W-1:0] cr_target,
   input  logic              cr_cond,
   input  logic              cr_flush
);
   localparam int SET_LO = OFF_W;
   localparam int TAG_LO = OFF_W + SET_W;
   localparam int HI_W   = ADDR_W - OFF_W;
   localparam logic [HI_W-1:0] ONE_BLK = HI_W'(1);

   initial begin
      assert (TAG_LO + TAG_W <= ADDR_W) else $error("tag field exceeds address");
      assert (WAYS >= 2 && (WAYS & (WAYS - 1)) == 0) else $error("WAYS must be a power of two");
   end

   logic [WAYS-1:0]   rd_vld, rd_cond;
   logic [TAG_W-1:0]  rd_tag [WAYS];
   logic [OFF_W-1:0]  rd_off [WAYS];
   logic [ADDR_W-1:0] rd_tgt [WAYS];
   logic              any_hit, hit_cond;
   logic [OFF_W-1:0]  hit_off;
   logic [ADDR_W-1:0] hit_tgt, seq_addr;
   logic [WAYS-1:0]   hit_sel;

   btb_store #(.SET_W(SET_W), .WAYS(WAYS), .TAG_W(TAG_W), .OFF_W(OFF_W), .TGT_W(ADDR_W)) i_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_set  (lk_addr[SET_LO +: SET_W]),
      .rd_vld  (rd_vld),
      .rd_tag  (rd_tag),
      .rd_off  (rd_off),
      .rd_tgt  (rd_tgt),
      .rd_cond (rd_cond),
      .wr_cmd  (btb_cmd_e'(cr_cmd)),
      .wr_set  (cr_addr[SET_LO +: SET_W]),
      .wr_tag  (cr_addr[TAG_LO +: TAG_W]),
      .wr_off  (cr_addr[OFF_W-1:0]),
      .wr_tgt  (cr_target),
      .wr_cond (cr_cond),
      .flush   (cr_flush)
   );

   btb_pick #(.WAYS(WAYS), .TAG_W(TAG_W), .OFF_W(OFF_W), .TGT_W(ADDR_W)) i_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .way_vld  (rd_vld),
      .way_tag  (rd_tag),
      .way_off  (rd_off),
      .way_tgt  (rd_tgt),
      .way_cond (rd_cond),
      .look_tag (lk_addr[TAG_LO +: TAG_W]),
      .look_off (lk_addr[OFF_W-1:0]),
      .any_hit  (any_hit),
      .hit_off  (hit_off),
      .hit_tgt  (hit_tgt),
      .hit_cond (hit_cond),
      .hit_sel  (hit_sel)
   );

   assign seq_addr = {lk_addr[ADDR_W-1:OFF_W] + ONE_BLK, {OFF_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_valid <= 1'b0;
         rs_hit   <= 1'b0;
         rs_off   <= '0;
         rs_next  <= '0;
         rs_cond  <= 1'b0;
      end else begin
         rs_valid <= lk_valid;
         rs_hit   <= any_hit;
         rs_off   <= any_hit ? hit_off : '0;
         rs_next  <= any_hit ? hit_tgt : seq_addr;
         rs_cond  <= any_hit && hit_cond;
      end
   end

   AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rs_valid); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rs_valid); // R7
   AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (rs_hit || rs_next == {$past(lk_addr[ADDR_W-1:OFF_W]) + ONE_BLK, {OFF_W{1'b0}}})); // R5
   AST_HIT_AT_OR_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (!rs_hit || rs_off >= $past(lk_addr[OFF_W-1:0]))); // R3
   AST_MISS_NOT_COND: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_hit |-> !rs_cond); // R5
endmodule

// File: tb/test_fblk_btb.sv
module test_fblk_btb;
   localparam int NSETS = 64;
   localparam int NWAYS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        rs_valid, rs_hit, rs_cond;
   logic [3:0]  rs_off;
   logic [31:0] rs_next;
   logic [1:0]  cr_cmd = 2'd0;
   logic [31:0] cr_addr = '0, cr_target = '0;
   logic        cr_cond = 1'b0, cr_flush = 1'b0;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   logic        m_vld  [NSETS][NWAYS];
   logic [9:0]  m_tag  [NSETS][NWAYS];
   logic [3:0]  m_off  [NSETS][NWAYS];
   logic [31:0] m_tgt  [NSETS][NWAYS];
   logic        m_cond [NSETS][NWAYS];
   int          m_rr   [NSETS];

   always #2 clk = ~clk;

   fblk_btb i_fblk_btb (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
      .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_off(rs_off), .rs_next(rs_next),
      .rs_cond(rs_cond), .cr_cmd(cr_cmd), .cr_addr(cr_addr), .cr_target(cr_target),
      .cr_cond(cr_cond), .cr_flush(cr_flush)
   );

   function automatic logic [31:0] mk(input int tag, input int set, input int off, input int hi);
      return {hi[11:0], tag[9:0], set[5:0], off[3:0]};
   endfunction

   task automatic report;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   task automatic model_apply(input logic [1:0] op, input logic [31:0] a, input logic [31:0] t,
                              input logic c, input logic fl);
      int s, v;
      s = int'(a[9:4]);
      v = -1;
      if (fl) begin
         for (int i = 0; i < NSETS; i++) for (int w = 0; w < NWAYS; w++) m_vld[i][w] = 1'b0;
         return;
      end
      if (op == 2'd1) begin
         for (int w = 0; w < NWAYS; w++)
            if (v < 0 && m_vld[s][w] && m_tag[s][w] == a[19:10] && m_off[s][w] == a[3:0]) v = w;
         for (int w = 0; w < NWAYS; w++)
            if (v < 0 && !m_vld[s][w]) v = w;
         if (v < 0) begin
            v = m_rr[s];
            m_rr[s] = (m_rr[s] + 1) % NWAYS;
         end
         m_vld[s][v] = 1'b1; m_tag[s][v] = a[19:10]; m_off[s][v] = a[3:0];
         m_tgt[s][v] = t;    m_cond[s][v] = c;
      end else if (op == 2'd2) begin
         for (int w = 0; w < NWAYS; w++)
            if (m_vld[s][w] && m_tag[s][w] == a[19:10] && m_off[s][w] == a[3:0]) m_vld[s][w] = 1'b0;
      end
   endtask

   // One clock: drive at the falling edge, compare one edge later at the next falling edge.
   task automatic cyc(input logic lv, input logic [31:0] la, input logic [1:0] op,
                      input logic [31:0] wa, input logic [31:0] wt, input logic wc,
                      input logic fl, input string rq);
      logic e_hit, e_cond;
      logic [3:0] e_off;
      logic [31:0] e_next;
      int nq, s;
      string tag;
      lk_valid = lv; lk_addr = la; cr_cmd = op; cr_addr = wa; cr_target = wt;
      cr_cond = wc; cr_flush = fl;
      s = int'(la[9:4]);
      e_hit = 1'b0; e_off = '0; e_cond = 1'b0; nq = 0;
      e_next = {la[31:4] + 28'd1, 4'd0};
      for (int w = 0; w < NWAYS; w++) begin
         if (m_vld[s][w] && m_tag[s][w] == la[19:10] && m_off[s][w] >= la[3:0]) begin
            nq++;
            if (!e_hit || m_off[s][w] < e_off) begin
               e_hit = 1'b1; e_off = m_off[s][w]; e_next = m_tgt[s][w]; e_cond = m_cond[s][w];
            end
         end
      end
      model_apply(op, wa, wt, wc, fl);
      @(posedge clk);
      @(negedge clk);
      tag = (rq != "") ? rq : (nq > 1) ? "R4" : e_hit ? "R6" : "R5";
      n_run++;
      if (!lv) begin
         if (rs_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R7: rs_valid=%0b expected 0", rs_valid);
         end
      end else if (rs_valid !== 1'b1 || rs_hit !== e_hit || rs_next !== e_next ||
                   rs_cond !== e_cond || (e_hit && rs_off !== e_off)) begin
         n_fail++;
         $display("FAIL %s: addr=%h got v=%0b hit=%0b off=%0d next=%h cond=%0b exp hit=%0b off=%0d next=%h cond=%0b",
                  tag, la, rs_valid, rs_hit, rs_off, rs_next, rs_cond, e_hit, e_off, e_next, e_cond);
      end
   endtask

   task automatic look(input logic [31:0] a, input string rq);
      cyc(1'b1, a, 2'd0, '0, '0, 1'b0, 1'b0, rq);
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] t, input logic c);
      cyc(1'b0, '0, 2'd1, a, t, c, 1'b0, "R7");
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         report();
      end
   end

   initial begin
      void'($urandom(32'd7531));
      for (int i = 0; i < NSETS; i++) begin
         m_rr[i] = 0;
         for (int w = 0; w < NWAYS; w++) m_vld[i][w] = 1'b0;
      end
      repeat (3) @(negedge clk);
      n_run++;
      if (rs_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: rs_valid=%0b in reset, expected 0", rs_valid);
      end
      rst_n = 1'b1;
      look(mk(7, 5, 0, 0), "R1");
      look(mk(0, 0, 0, 0), "R1");
      cyc(1'b0, '0, 2'd0, '0, '0, 1'b0, 1'b0, "R7");

      // R12: write and lookup to the same block in one cycle
      cyc(1'b1, mk(7, 5, 0, 0), 2'd1, mk(7, 5, 2, 0), 32'h1000_0000, 1'b1, 1'b0, "R12");
      look(mk(7, 5, 0, 0), "R12");
      look(mk(7, 5, 3, 0), "R3");
      look(mk(7, 5, 2, 3), "R3");
      wr(mk(7, 5, 9, 0), 32'h2000_0000, 1'b0);
      wr(mk(7, 5, 5, 0), 32'h3000_0000, 1'b1);
      look(mk(7, 5, 0, 0), "R4");
      look(mk(7, 5, 3, 0), "R4");
      look(mk(7, 5, 6, 0), "R4");
      look(mk(7, 5, 10, 0), "R5");
      // R8: rewrite offset 5 in place
      wr(mk(7, 5, 5, 0), 32'h3333_0000, 1'b0);
      look(mk(7, 5, 3, 0), "R8");
      wr(mk(7, 5, 12, 0), 32'h4000_0000, 1'b1);
      look(mk(7, 5, 10, 0), "R8");
      // R9: set full, replacement walks round-robin from way 0
      wr(mk(7, 5, 14, 0), 32'h5000_0000, 1'b0);
      look(mk(7, 5, 0, 0), "R9");
      wr(mk(7, 5, 1, 0), 32'h6000_0000, 1'b0);
      look(mk(7, 5, 6, 0), "R9");
      look(mk(7, 5, 0, 0), "R9");
      // R2: foreign tag or other set
      look(mk(8, 5, 0, 0), "R2");
      look(mk(7, 6, 0, 0), "R2");
      look(mk(7, 5, 0, 12'hABC), "R2");
      // R10: drop offset 5
      cyc(1'b0, '0, 2'd2, mk(7, 5, 5, 0), '0, 1'b0, 1'b0, "R10");
      look(mk(7, 5, 3, 0), "R10");
      // R5: sequential wrap
      look(32'hFFFF_FFF7, "R5");
      // R11: flush wins over a write in the same cycle
      cyc(1'b0, '0, 2'd1, mk(3, 3, 3, 0), 32'h7000_0000, 1'b0, 1'b1, "R11");
      look(mk(7, 5, 0, 0), "R11");
      look(mk(3, 3, 0, 0), "R11");

      // random traffic over two sets and two tags
      for (int i = 0; i < 3000; i++) begin
         int r;
         logic [1:0] op;
         r = int'($urandom_range(99));
         op = (r < 40) ? 2'd1 : (r < 55) ? 2'd2 : 2'd0;
         cyc($urandom_range(9) < 8,
             mk(int'($urandom_range(1)) + 1, int'($urandom_range(1)) + 20, int'($urandom_range(15)), int'($urandom_range(4095))),
             op,
             mk(int'($urandom_range(1)) + 1, int'($urandom_range(1)) + 20, int'($urandom_range(15)), int'($urandom_range(4095))),
             $urandom, 1'($urandom_range(1)), $urandom_range(199) == 0, "");
      end
      done = 1'b1;
      report();
   end
endmodule